// File: doc/BRIEF.md
# Capture-Only Boundary-Scan Test Port

This block is the serial test port of a memory device whose boundary scan can only observe. A four-wire serial interface walks a sixteen-state controller, loads a 3-bit instruction and then shifts one of three data paths between the serial input and the serial output. The three paths are a 32-bit identification register, a single bypass bit and a boundary register of `PINS` bits. The boundary register takes a snapshot of the device's pin values, which arrive as a parallel vector. The port never drives the device pins and never preloads them. Its one effect on the device is a request that puts the memory outputs in high impedance.

Instruction codes (bit 0 is shifted in first): `000` capture with outputs held high-Z, `001` identify, `010` sample with outputs held high-Z, `100` sample, `111` bypass. The reserved codes `011`, `101` and `110` select the bypass bit. Shifted data has no destination, so the update step of the data column changes nothing.

The controller states are Reset, Idle, DR-Select, DR-Capture, DR-Shift, DR-Exit1, DR-Pause, DR-Exit2, DR-Update, IR-Select, IR-Capture, IR-Shift, IR-Exit1, IR-Pause, IR-Exit2 and IR-Update. Each transition is taken on the rising edge, and the value of `mode_sel` picks the next state (0 / 1):

- Reset → Idle / Reset
- Idle → Idle / DR-Select
- DR-Select → DR-Capture / IR-Select
- IR-Select → IR-Capture / Reset
- x-Capture → x-Shift / x-Exit1
- x-Shift → x-Shift / x-Exit1
- x-Exit1 → x-Pause / x-Update
- x-Pause → x-Pause / x-Exit2
- x-Exit2 → x-Shift / x-Update
- x-Update → Idle / DR-Select

Top module: `scan_port`

## Requirements
- R1: The controller follows the sixteen-state transition list above. Five consecutive rising edges with `mode_sel` high reach Reset from any state. `test_rst_n` low forces Reset immediately, without waiting for a clock edge.
- R2: The instruction shift stage loads `scan_in` into its bit 2 and shifts right on each IR-Shift edge. The active instruction takes the shifted code only on the edge that leaves IR-Update, and keeps its value in every other state, including IR-Pause.
- R3: After `test_rst_n` and on every edge spent in Reset, the active instruction becomes identify (`001`) and `hiz_req` is 0.
- R4: IR-Capture loads `001` into the instruction shift stage. The low two bits are therefore `01`, and these bits are shifted out least significant bit first.
- R5: Under identify, DR-Capture loads the 32-bit `ID_VALUE`, whose bit 0 is 1. The value is shifted out least significant bit first, and `scan_in` follows it.
- R6: Under bypass (`111`) and under the reserved codes `011`, `101` and `110`, the path is a single bit that captures 0. The first output bit is 0, and `scan_in` then appears one clock later.
- R7: Under sample (`100`), DR-Capture loads `pin_vals` into the boundary register, which is shifted out starting at bit 0. `hiz_req` is 0.
- R8: Under code `000`, the capture and shift behave exactly as in R7, and `hiz_req` is 1.
- R9: Under code `010`, the boundary register is in the path as in R7, and `hiz_req` is 1.
- R10: DR-Update has no effect. `hiz_req` does not change, and bits shifted into the boundary register never reach an output: the next capture replaces them with fresh pin values.
- R11: `scan_out` changes only on the falling edge of `test_clk`. `scan_out_en` is 1 only while the controller is in IR-Shift or DR-Shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Serial test clock |
| test_rst_n | input | 1 | Asynchronous active-low port reset |
| mode_sel | input | 1 | State-walk select, sampled on the rising edge |
| scan_in | input | 1 | Serial data into the selected path |
| pin_vals | input | PINS | Parallel device pin values for capture |
| scan_out | output | 1 | Serial data out, updated on the falling edge |
| scan_out_en | output | 1 | Enable for the serial output driver |
| hiz_req | output | 1 | Request to hold the memory outputs in high impedance |

## Verification
The hardest case to reach from the ports is a new code that has been fully shifted in but must not yet be active. The stimulus makes `000` active, so `hiz_req` is high. It then shifts in the bypass code and parks the controller in IR-Pause and IR-Exit2. During that time `hiz_req` must stay high, and it may fall only after IR-Update has been left. A second hard case is proving that Update-DR has no effect. The bench shifts a marker pattern into the boundary register, passes through DR-Update, changes the pins, and confirms that the next scan returns the new pins and no trace of the marker. Random instruction codes, pin vectors and shift data are then checked against a chain-length model.

// File: rtl/scan_pkg.sv
package scan_pkg;
    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
    } tap_state_t;

    typedef enum logic [1:0] {PATH_ID, PATH_BSR, PATH_BYP} path_t;

    localparam logic [IR_W-1:0] OP_CAPT_HIZ   = 3'b000;
    localparam logic [IR_W-1:0] OP_IDENT      = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE_HIZ = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE     = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS     = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPT_VAL   = 3'b001;
endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state,
    output logic       in_reset,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       upd_ir,
    output logic       cap_dr,
    output logic       sh_dr
);
    tap_state_t next_st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= next_st;
    end

    always_comb begin
        unique case (state)
            ST_RESET:    next_st = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     next_st = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   next_st = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   next_st = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: next_st = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: next_st = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: next_st = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: next_st = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   next_st = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   next_st = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   next_st = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: next_st = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: next_st = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: next_st = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: next_st = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   next_st = tms ? ST_DR_SEL   : ST_IDLE;
        endcase
    end

    always_comb begin
        in_reset = (state == ST_RESET);
        cap_ir   = (state == ST_IR_CAP);
        sh_ir    = (state == ST_IR_SHIFT);
        upd_ir   = (state == ST_IR_UPD);
        cap_dr   = (state == ST_DR_CAP);
        sh_dr    = (state == ST_DR_SHIFT);
    end
endmodule

// File: rtl/scan_instr.sv
module scan_instr
    import scan_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_reset,
    input  logic            cap_ir,
    input  logic            sh_ir,
    input  logic            upd_ir,
    input  logic            sin,
    output logic [IR_W-1:0] shift_q,
    output logic [IR_W-1:0] active_q,
    output path_t           path,
    output logic            hiz
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q  <= IR_CAPT_VAL;
            active_q <= OP_IDENT;
        end else begin
            if (in_reset)    active_q <= OP_IDENT;
            else if (upd_ir) active_q <= shift_q;
            if (cap_ir)      shift_q  <= IR_CAPT_VAL;
            else if (sh_ir)  shift_q  <= {sin, shift_q[IR_W-1:1]};
        end
    end

    always_comb begin
        case (active_q)
            OP_IDENT:                          path = PATH_ID;
            OP_CAPT_HIZ, OP_SAMPLE_HIZ, OP_SAMPLE: path = PATH_BSR;
            default:                           path = PATH_BYP;
        endcase
        hiz = (active_q == OP_CAPT_HIZ) || (active_q == OP_SAMPLE_HIZ);
    end
endmodule

// File: rtl/scan_data.sv
module scan_data
    import scan_pkg::*;
#(
    parameter int          PINS     = 8,
    parameter logic [31:0] ID_VALUE = 32'h1A5C_0E3B
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap,
    input  logic            sh,
    input  path_t           path,
    input  logic            sin,
    input  logic [PINS-1:0] pins,
    output logic            sout,
    output logic [PINS-1:0] bsr_q
);
    localparam int ID_W = 32;

    logic [ID_W-1:0] id_q;
    logic            byp_q;
    logic [PINS-1:0] bsr_shifted;

    generate
        if (PINS > 1) begin : g_wide
            assign bsr_shifted = {sin, bsr_q[PINS-1:1]};
        end else begin : g_single
            assign bsr_shifted = sin;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q  <= ID_VALUE;
            byp_q <= 1'b0;
            bsr_q <= '0;
        end else begin
            unique case (path)
                PATH_ID: begin
                    if (cap)     id_q <= ID_VALUE;
                    else if (sh) id_q <= {sin, id_q[ID_W-1:1]};
                end
                PATH_BSR: begin
                    if (cap)     bsr_q <= pins;
                    else if (sh) bsr_q <= bsr_shifted;
                end
                PATH_BYP: begin
                    if (cap)     byp_q <= 1'b0;
                    else if (sh) byp_q <= sin;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (path)
            PATH_ID:  sout = id_q[0];
            PATH_BSR: sout = bsr_q[0];
            default:  sout = byp_q;
        endcase
    end
endmodule

// File: rtl/scan_port.sv
module scan_port
    import scan_pkg::*;
#(
    parameter int          PINS     = 8,
    parameter logic [31:0] ID_VALUE = 32'h1A5C_0E3B
) (
    input  logic            test_clk,
    input  logic            test_rst_n,
    input  logic            mode_sel,
    input  logic            scan_in,
    input  logic [PINS-1:0] pin_vals,
    output logic            scan_out,
    output logic            scan_out_en,
    output logic            hiz_req
);
    tap_state_t      st;
    logic            in_reset, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr;
    logic [IR_W-1:0] ir_shift, ir_active;
    path_t           dr_path;
    logic            dr_sout;
    logic [PINS-1:0] bsr_q;

    scan_fsm u_fsm (
        .clk(test_clk), .rst_n(test_rst_n), .tms(mode_sel), .state(st),
        .in_reset(in_reset), .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
        .cap_dr(cap_dr), .sh_dr(sh_dr)
    );

    scan_instr u_ir (
        .clk(test_clk), .rst_n(test_rst_n), .in_reset(in_reset), .cap_ir(cap_ir),
        .sh_ir(sh_ir), .upd_ir(upd_ir), .sin(scan_in), .shift_q(ir_shift),
        .active_q(ir_active), .path(dr_path), .hiz(hiz_req)
    );

    scan_data #(.PINS(PINS), .ID_VALUE(ID_VALUE)) u_dr (
        .clk(test_clk), .rst_n(test_rst_n), .cap(cap_dr), .sh(sh_dr), .path(dr_path),
        .sin(scan_in), .pins(pin_vals), .sout(dr_sout), .bsr_q(bsr_q)
    );

    always_ff @(negedge test_clk or negedge test_rst_n) begin
        if (!test_rst_n) begin
            scan_out    <= 1'b0;
            scan_out_en <= 1'b0;
        end else begin
            scan_out    <= sh_ir ? ir_shift[0] : dr_sout;
            scan_out_en <= sh_ir | sh_dr;
        end
    end
endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
    import scan_pkg::*;
#(
    parameter int PINS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tms,
    input tap_state_t      state,
    input logic [IR_W-1:0] ir_shift,
    input logic [IR_W-1:0] ir_active,
    input logic [PINS-1:0] bsr,
    input logic            hiz_req,
    input logic            out_en
);
    assert_reset_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESET && tms) |=> (state == ST_RESET));

    assert_ir_only_on_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IR_UPD && state != ST_RESET) |=> $stable(ir_active));

    assert_reset_ident_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESET) |=> (ir_active == OP_IDENT && !hiz_req));

    assert_ir_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IR_CAP) |=> (ir_shift[1:0] == 2'b01));

    assert_update_dr_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DR_UPD) |=> ($stable(bsr) && $stable(hiz_req)));

    assert_out_en_shift_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT));
endmodule

bind scan_port scan_port_chk #(.PINS(PINS)) u_chk (
    .clk(test_clk), .rst_n(test_rst_n), .tms(mode_sel), .state(st),
    .ir_shift(ir_shift), .ir_active(ir_active), .bsr(bsr_q),
    .hiz_req(hiz_req), .out_en(scan_out_en)
);

// File: tb/scan_port_test.sv
module scan_port_test;
    localparam int          CLK_PERIOD = 100;
    localparam int          PINS       = 12;
    localparam logic [31:0] IDV        = 32'h1A5C_0E3B;

    logic            test_clk = 1'b0;
    logic            test_rst_n = 1'b0;
    logic            mode_sel = 1'b1;
    logic            scan_in = 1'b0;
    logic [PINS-1:0] pin_vals = '0;
    logic            scan_out, scan_out_en, hiz_req;

    int total = 0;
    int fails = 0;
    bit done = 0;

    scan_port #(.PINS(PINS), .ID_VALUE(IDV)) uut (
        .test_clk(test_clk), .test_rst_n(test_rst_n), .mode_sel(mode_sel),
        .scan_in(scan_in), .pin_vals(pin_vals), .scan_out(scan_out),
        .scan_out_en(scan_out_en), .hiz_req(hiz_req)
    );

    always #(CLK_PERIOD / 2) test_clk = ~test_clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int chain_len(input logic [2:0] code);
        case (code)
            3'b001:                 return 32;
            3'b000, 3'b010, 3'b100: return PINS;
            default:                return 1;
        endcase
    endfunction

    function automatic logic exp_hiz(input logic [2:0] code);
        return (code == 3'b000) || (code == 3'b010);
    endfunction

    function automatic logic [63:0] exp_out(input int len, input logic [63:0] cap,
                                            input logic [63:0] din, input int n);
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = (i < len) ? cap[i] : din[i - len];
        return r;
    endfunction

    task automatic step(input logic tms, input logic tdi);
        mode_sel = tms;
        scan_in  = tdi;
        @(posedge test_clk);
        @(negedge test_clk);
        #1;
    endtask

    task automatic shift_seq(input int n, input logic [63:0] din, output logic [63:0] dout);
        bit en_bad = 0;
        bit edge_bad = 0;
        dout = '0;
        for (int i = 0; i < n; i++) begin
            logic pre;
            pre     = scan_out;
            dout[i] = pre;
            if (scan_out_en !== 1'b1) en_bad = 1;
            mode_sel = (i == n - 1);
            scan_in  = din[i];
            @(posedge test_clk);
            #1;
            if (scan_out !== pre) edge_bad = 1;
            @(negedge test_clk);
            #1;
        end
        check("R11 out_en high while shifting", {63'd0, en_bad}, 64'd0);
        check("R11 scan_out steady across rising edge", {63'd0, edge_bad}, 64'd0);
    endtask

    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
        logic [63:0] d;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        shift_seq(3, {61'd0, code}, d);
        step(1, 0); step(0, 0);
        cap = d[2:0];
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        step(1, 0); step(0, 0); step(0, 0);
        shift_seq(n, din, dout);
        step(1, 0);
        check("R10 hiz_req unchanged in DR-Update", {63'd0, hiz_req}, {63'd0, exp_hiz(uut_code)});
        step(0, 0);
        check("R11 out_en low outside shift", {63'd0, scan_out_en}, 64'd0);
    endtask

    logic [2:0] uut_code;

    initial begin
        repeat (150000) @(posedge test_clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [63:0] dout, din;
        logic [2:0]  cap;
        logic [PINS-1:0] pa, pb;
        int seed;
        seed = $urandom(32'd4242);
        uut_code = 3'b001;

        repeat (2) @(negedge test_clk);
        #1;
        check("R3 reset hiz_req", {63'd0, hiz_req}, 64'd0);
        check("R11 reset out_en", {63'd0, scan_out_en}, 64'd0);
        test_rst_n = 1'b1;
        @(negedge test_clk); #1;
        step(0, 0);

        // R5 / R3: identify active after reset
        din = 64'h0000_00A5_0000_0000;
        scan_dr(40, 64'h0000_00C3_5A5A_0F0F, dout);
        check("R5 identify value and follow-on data", dout,
              exp_out(32, {32'd0, IDV}, 64'h0000_00C3_5A5A_0F0F, 40));
        check("R5 id lsb is one", {63'd0, dout[0]}, 64'd1);

        // R4 / R6: bypass
        load_ir(3'b111, cap); uut_code = 3'b111;
        check("R4 IR capture value", {61'd0, cap}, 64'd1);
        scan_dr(8, 64'hB6, dout);
        check("R6 bypass one-bit delay", dout, exp_out(1, 64'd0, 64'hB6, 8));

        // R6: reserved codes
        foreach (cap[i]) begin end
        for (int k = 0; k < 3; k++) begin
            logic [2:0] rc;
            rc = (k == 0) ? 3'b011 : (k == 1) ? 3'b101 : 3'b110;
            load_ir(rc, cap); uut_code = rc;
            check("R6 reserved code hiz_req", {63'd0, hiz_req}, 64'd0);
            scan_dr(6, 64'h2D, dout);
            check("R6 reserved code selects bypass", dout, exp_out(1, 64'd0, 64'h2D, 6));
        end

        // R7 / R10: sample, then prove shifted data is inert
        pa = 12'hA3C; pb = 12'h5E1;
        load_ir(3'b100, cap); uut_code = 3'b100;
        check("R7 sample hiz_req low", {63'd0, hiz_req}, 64'd0);
        pin_vals = pa;
        scan_dr(PINS + 4, 64'hFFFF, dout);
        check("R7 sample capture", dout, exp_out(PINS, {52'd0, pa}, 64'hFFFF, PINS + 4));
        pin_vals = pb;
        scan_dr(PINS, 64'h0, dout);
        check("R10 next capture replaces shifted data", dout, {52'd0, pb});

        // R8
        load_ir(3'b000, cap); uut_code = 3'b000;
        check("R8 capture-hiz asserts hiz_req", {63'd0, hiz_req}, 64'd1);
        pin_vals = 12'h3C6;
        scan_dr(PINS, 64'h0, dout);
        check("R8 capture like sample", dout, {52'd0, 12'h3C6});

        // R2: new code parked in IR-Pause is not active yet
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        shift_seq(3, 64'h7, dout);
        step(0, 0); step(0, 0);
        check("R2 code inactive in IR-Pause", {63'd0, hiz_req}, 64'd1);
        step(1, 0);
        check("R2 code inactive in IR-Exit2", {63'd0, hiz_req}, 64'd1);
        step(1, 0);
        check("R2 code inactive in IR-Update", {63'd0, hiz_req}, 64'd1);
        step(0, 0); uut_code = 3'b111;
        check("R2 code active after IR-Update", {63'd0, hiz_req}, 64'd0);

        // R9
        load_ir(3'b010, cap); uut_code = 3'b010;
        check("R9 sample-hiz asserts hiz_req", {63'd0, hiz_req}, 64'd1);
        pin_vals = 12'h0F3;
        scan_dr(PINS + 2, 64'h3, dout);
        check("R9 boundary path", dout, exp_out(PINS, {52'd0, 12'h0F3}, 64'h3, PINS + 2));

        // R1: five mode_sel-high edges reach Reset
        for (int k = 0; k < 5; k++) step(1, 0);
        check("R1 state walk reset clears hiz_req", {63'd0, hiz_req}, 64'd0);
        step(0, 0); uut_code = 3'b001;
        scan_dr(32, 64'h0, dout);
        check("R1 identify after state walk reset", dout, {32'd0, IDV});

        // R1: asynchronous reset
        load_ir(3'b000, cap); uut_code = 3'b000;
        check("R8 hiz_req before async reset", {63'd0, hiz_req}, 64'd1);
        #5 test_rst_n = 1'b0;
        #1;
        check("R1 async reset without clock", {63'd0, hiz_req}, 64'd0);
        @(negedge test_clk); test_rst_n = 1'b1; #1;
        step(0, 0); uut_code = 3'b001;

        // random mix
        for (int it = 0; it < 24; it++) begin
            logic [2:0] rc;
            logic [PINS-1:0] pv;
            int n;
            rc = 3'($urandom_range(7, 0));
            pv = PINS'($urandom);
            din = {$urandom, $urandom};
            load_ir(rc, cap); uut_code = rc;
            check("R4 IR capture (random)", {61'd0, cap}, 64'd1);
            check("R2 hiz_req for random code", {63'd0, hiz_req}, {63'd0, exp_hiz(rc)});
            pin_vals = pv;
            n = 40;
            scan_dr(n, din, dout);
            check("R7 random path contents",
                  dout, exp_out(chain_len(rc),
                                (rc == 3'b001) ? {32'd0, IDV} :
                                (chain_len(rc) == 1) ? 64'd0 : {52'd0, pv},
                                din, n));
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule